// File: doc/BRIEF.md
# Time-Multiplexed Ensemble Performance Predictor

This block evaluates small feed-forward neural networks in fixed point to predict how an application will perform under a candidate resource allocation. One physical pipeline serves sixteen virtual networks. The networks are grouped as four applications with four ensemble members each. Each network has its own weight set, and the set is chosen on every cycle by a selector that travels down the pipeline with the data. A new evaluation can start on every clock, so the sixteen networks run back to back and one complete query point finishes every sixteen cycles.

Each network takes twelve signed Q8.8 inputs. These feed four hidden units, and the hidden units feed a single output unit. Every unit adds a bias weight to its multiply-accumulate result. It then passes the sum through a 50-entry sigmoid-shaped table, and sums beyond the table's range clamp to its end entries. A collector then gathers the four ensemble outputs of each application. Once an application is complete, the collector emits the mean of its four outputs and the sum of their absolute deviations from that mean, which a search controller can use as a cheap confidence measure. Weights are loaded through a single-word write port while the pipeline is idle.

Top module: `np_predictor`

## Requirements
- R1: After reset, out_valid is low, every weight of every set is zero and no ensemble member is pending, so a first complete query with unwritten weights yields out_mean 128 and out_spread 0.
- R2: Each unit forms the full-precision sum of its bias weight times one plus the product of every input with its weight (Q8.8 by Q8.8 gives Q16.16, with no intermediate rounding). Hidden units use the twelve inputs, and the output unit uses the four hidden activations as unsigned Q8.8 values.
- R3: The activation of a Q16.16 sum S is found as follows. Let d be floor(S / 2^14), that is, the sum quantized in steps of 0.25. The result is the table entry at index d+25, whose value is 128 + trunc(128*d / (|d|+4)). A zero sum gives 128.
- R4: A quantized sum below -25 uses d = -25, which gives 18. A quantized sum above 24 uses d = 24, which gives 237.
- R5: Suppose the input that completes an application is accepted at rising edge t. Its result is then driven on the outputs, with out_valid high, from rising edge t+16 until the next edge.
- R6: An input with in_valid high is accepted on every cycle, without a stall. in_sel[3:2] names the application and in_sel[1:0] names the ensemble member, and all sixteen selections may follow one another on consecutive cycles.
- R7: While in_valid is low, a cycle with wr_en high writes wr_data into weight wr_idx of set wr_set, and the new value is used by inputs accepted afterwards. For hidden unit h, index h*13 holds the bias and index h*13+1+i holds the weight of input i. Index 52 holds the output unit's bias, and index 53+h holds the output unit's weight for hidden unit h.
- R8: out_mean equals the truncated quotient of the sum of the application's four member outputs by four.
- R9: out_spread equals the sum over the four members of the absolute difference between each member output and out_mean.
- R10: An application's result is released only when all four of its members have arrived since its previous release. The members may arrive in any order and may interleave with other applications. out_app and out_tag are taken from the member that arrives last.
- R11: The output unit of an evaluation uses the weights of the same set that its hidden units used, even when the selection changes on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Start one network evaluation this cycle |
| in_sel | input | 4 | Weight set / virtual network: application in [3:2], member in [1:0] |
| in_tag | input | 8 | Query tag carried with the evaluation |
| in_x | input | 192 | Twelve signed Q8.8 inputs, input i in bits [16i+15:16i] |
| wr_en | input | 1 | Weight write strobe |
| wr_set | input | 4 | Weight set to write |
| wr_idx | input | 6 | Weight index within the set |
| wr_data | input | 16 | Signed Q8.8 weight value |
| out_valid | output | 1 | Result of one application is present |
| out_app | output | 2 | Application of the result |
| out_tag | output | 8 | Tag of the last arriving member |
| out_mean | output | 16 | Ensemble mean, unsigned Q8.8 |
| out_spread | output | 16 | Sum of absolute deviations from the mean |

## Verification
The bench builds the block with its default parameters: twelve inputs, four hidden units, four applications of four members each, and an eight-bit tag. This gives the full sixteen-set rotation that the search controller uses. It also makes both table clamps reachable by using near-full-scale weights and inputs, and it covers interleaved and out-of-order member arrival across applications. A behavioural model predicts every output slot from the stated arithmetic, and each cycle's out_valid and result fields are compared against it.

// File: rtl/np_pkg.sv
package np_pkg;
    localparam int DW        = 16;   // Q8.8 data and weights
    localparam int FRAC      = 8;
    localparam int PW        = 2 * DW;
    localparam int AW        = PW + 4;
    localparam int MUL_LAT   = 4;
    localparam int ADD_LAT   = 3;
    localparam int LAYER_LAT = MUL_LAT + ADD_LAT + 1;
    localparam int TOTAL_LAT = 2 * LAYER_LAT + 1;
    localparam int LUT_N     = 50;
    localparam int LUT_MID   = 25;
    localparam int Q_STEP    = 6;    // quantization step 2^-2 in Q8.8
    localparam int IDX_SHIFT = FRAC + Q_STEP;
    localparam int LUT_IW    = $clog2(LUT_N);

    function automatic logic [DW-1:0] act_entry(input int k);
        int d;
        int ad;
        d  = k - LUT_MID;
        ad = (d < 0) ? -d : d;
        return DW'(128 + (128 * d) / (ad + 4));
    endfunction
endpackage

// File: rtl/np_neuron.sv
module np_neuron
    import np_pkg::*;
#(
    parameter int N_T = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_T-1:0][DW-1:0]    x,
    input  logic [N_T:0][DW-1:0]      w,
    output logic [DW-1:0]             act
);
    localparam int NT = N_T + 1;

    typedef struct packed {
        logic [MUL_LAT-1:0][NT-1:0][PW-1:0] prod;
        logic [3:0][AW-1:0]                 grp;
        logic [1:0][AW-1:0]                 pair;
        logic [AW-1:0]                      total;
        logic [DW-1:0]                      act;
    } st_t;

    st_t st_d, st_q;
    logic [DW-1:0] lut [LUT_N];

    for (genvar k = 0; k < LUT_N; k++) begin : g_lut
        assign lut[k] = act_entry(k);
    end

    always_comb begin
        logic signed [AW-1:0] acc;
        logic signed [AW-1:0] ds;
        logic [LUT_IW-1:0]    idx;
        st_d = st_q;
        st_d.prod[0][0] = PW'($signed(w[0])) <<< FRAC;
        for (int i = 0; i < N_T; i++) begin
            st_d.prod[0][i+1] = PW'($signed(x[i])) * PW'($signed(w[i+1]));
        end
        for (int s = 1; s < MUL_LAT; s++) begin
            st_d.prod[s] = st_q.prod[s-1];
        end
        for (int g = 0; g < 4; g++) begin
            acc = '0;
            for (int j = 0; j < 4; j++) begin
                if (g * 4 + j < NT) begin
                    acc = acc + AW'($signed(st_q.prod[MUL_LAT-1][g*4+j]));
                end
            end
            st_d.grp[g] = acc;
        end
        st_d.pair[0] = AW'($signed(st_q.grp[0]) + $signed(st_q.grp[1]));
        st_d.pair[1] = AW'($signed(st_q.grp[2]) + $signed(st_q.grp[3]));
        st_d.total   = AW'($signed(st_q.pair[0]) + $signed(st_q.pair[1]));
        ds = $signed(st_q.total) >>> IDX_SHIFT;
        if (ds < -LUT_MID) begin
            idx = '0;
        end else if (ds > LUT_N - 1 - LUT_MID) begin
            idx = LUT_IW'(LUT_N - 1);
        end else begin
            idx = LUT_IW'(int'(ds) + LUT_MID);
        end
        st_d.act = lut[idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;
endmodule

// File: rtl/np_wmem.sv
module np_wmem
    import np_pkg::*;
#(
    parameter int N_SET = 16,
    parameter int N_HW  = 52,
    parameter int N_OW  = 5,
    parameter int SEL_W = 4,
    parameter int WI_W  = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_set,
    input  logic [WI_W-1:0]            wr_idx,
    input  logic [DW-1:0]              wr_data,
    input  logic [SEL_W-1:0]           sel_a,
    input  logic [SEL_W-1:0]           sel_b,
    output logic [N_HW-1:0][DW-1:0]    rd_a,
    output logic [N_OW-1:0][DW-1:0]    rd_b
);
    localparam int N_W = N_HW + N_OW;

    logic [N_SET-1:0][N_W-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && int'(wr_idx) < N_W) begin
            mem_d[wr_set][wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_a = mem_q[sel_a][N_HW-1:0];
    assign rd_b = mem_q[sel_b][N_W-1:N_HW];
endmodule

// File: rtl/np_avg.sv
module np_avg
    import np_pkg::*;
#(
    parameter int N_APP  = 4,
    parameter int N_MEMB = 4,
    parameter int TAG_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [$clog2(N_APP)-1:0]    in_app,
    input  logic [$clog2(N_MEMB)-1:0]   in_memb,
    input  logic [TAG_W-1:0]            in_tag,
    input  logic [DW-1:0]               in_val,
    output logic                        out_valid,
    output logic [$clog2(N_APP)-1:0]    out_app,
    output logic [TAG_W-1:0]            out_tag,
    output logic [DW-1:0]               out_mean,
    output logic [DW-1:0]               out_spread
);
    localparam int APP_W  = $clog2(N_APP);
    localparam int MEMB_W = $clog2(N_MEMB);
    localparam int SUM_W  = DW + MEMB_W;

    typedef struct packed {
        logic [N_APP-1:0][N_MEMB-1:0][DW-1:0] vals;
        logic [N_APP-1:0][N_MEMB-1:0]         have;
        logic                                 ov;
        logic [APP_W-1:0]                     oapp;
        logic [TAG_W-1:0]                     otag;
        logic [DW-1:0]                        omean;
        logic [DW-1:0]                        ospr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [N_MEMB-1:0][DW-1:0] cur;
        logic [N_MEMB-1:0]         flags;
        logic [SUM_W-1:0]          sum;
        logic [SUM_W-1:0]          spr;
        logic [DW-1:0]             mean;
        st_d    = st_q;
        st_d.ov = 1'b0;
        cur     = st_q.vals[in_app];
        cur[in_memb] = in_val;
        flags   = st_q.have[in_app];
        flags[in_memb] = 1'b1;
        sum  = '0;
        spr  = '0;
        for (int m = 0; m < N_MEMB; m++) begin
            sum = sum + SUM_W'(cur[m]);
        end
        mean = DW'(sum >> MEMB_W);
        for (int m = 0; m < N_MEMB; m++) begin
            spr = spr + SUM_W'((cur[m] >= mean) ? (cur[m] - mean) : (mean - cur[m]));
        end
        if (in_valid) begin
            st_d.vals[in_app] = cur;
            if (&flags) begin
                st_d.have[in_app] = '0;
                st_d.ov    = 1'b1;
                st_d.oapp  = in_app;
                st_d.otag  = in_tag;
                st_d.omean = mean;
                st_d.ospr  = DW'(spr);
            end else begin
                st_d.have[in_app] = flags;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.ov;
    assign out_app    = st_q.oapp;
    assign out_tag    = st_q.otag;
    assign out_mean   = st_q.omean;
    assign out_spread = st_q.ospr;
endmodule

// File: rtl/np_predictor.sv
module np_predictor
    import np_pkg::*;
#(
    parameter int N_IN   = 12,
    parameter int N_HID  = 4,
    parameter int N_APP  = 4,
    parameter int N_MEMB = 4,
    parameter int TAG_W  = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    in_valid,
    input  logic [$clog2(N_APP*N_MEMB)-1:0]         in_sel,
    input  logic [TAG_W-1:0]                        in_tag,
    input  logic [N_IN*DW-1:0]                      in_x,
    input  logic                                    wr_en,
    input  logic [$clog2(N_APP*N_MEMB)-1:0]         wr_set,
    input  logic [$clog2(N_HID*(N_IN+1)+N_HID+1)-1:0] wr_idx,
    input  logic [DW-1:0]                           wr_data,
    output logic                                    out_valid,
    output logic [$clog2(N_APP)-1:0]                out_app,
    output logic [TAG_W-1:0]                        out_tag,
    output logic [DW-1:0]                           out_mean,
    output logic [DW-1:0]                           out_spread
);
    localparam int N_SET    = N_APP * N_MEMB;
    localparam int SEL_W    = $clog2(N_SET);
    localparam int APP_W    = $clog2(N_APP);
    localparam int MEMB_W   = $clog2(N_MEMB);
    localparam int HW       = N_IN + 1;
    localparam int N_HW     = N_HID * HW;
    localparam int N_OW     = N_HID + 1;
    localparam int WI_W     = $clog2(N_HW + N_OW);
    localparam int PIPE_LAT = 2 * LAYER_LAT;

    typedef struct packed {
        logic             v;
        logic [SEL_W-1:0] sel;
        logic [TAG_W-1:0] tag;
    } meta_t;

    meta_t [PIPE_LAT-1:0] meta_d, meta_q;

    logic [N_IN-1:0][DW-1:0]  x_in;
    logic [N_HW-1:0][DW-1:0]  w_hid;
    logic [N_OW-1:0][DW-1:0]  w_out;
    logic [N_HID-1:0][DW-1:0] hact;
    logic [DW-1:0]            pred;

    assign x_in = in_x;

    always_comb begin
        meta_d[0] = '{v: in_valid, sel: in_sel, tag: in_tag};
        for (int s = 1; s < PIPE_LAT; s++) begin
            meta_d[s] = meta_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
        end else begin
            meta_q <= meta_d;
        end
    end

    np_wmem #(
        .N_SET (N_SET),
        .N_HW  (N_HW),
        .N_OW  (N_OW),
        .SEL_W (SEL_W),
        .WI_W  (WI_W)
    ) u_wmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_set  (wr_set),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .sel_a   (in_sel),
        .sel_b   (meta_q[LAYER_LAT-1].sel),
        .rd_a    (w_hid),
        .rd_b    (w_out)
    );

    for (genvar h = 0; h < N_HID; h++) begin : g_hid
        np_neuron #(.N_T(N_IN)) u_hid (
            .clk   (clk),
            .rst_n (rst_n),
            .x     (x_in),
            .w     (w_hid[h*HW +: HW]),
            .act   (hact[h])
        );
    end

    np_neuron #(.N_T(N_HID)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .x     (hact),
        .w     (w_out),
        .act   (pred)
    );

    np_avg #(
        .N_APP  (N_APP),
        .N_MEMB (N_MEMB),
        .TAG_W  (TAG_W)
    ) u_avg (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (meta_q[PIPE_LAT-1].v),
        .in_app     (meta_q[PIPE_LAT-1].sel[SEL_W-1 -: APP_W]),
        .in_memb    (meta_q[PIPE_LAT-1].sel[MEMB_W-1:0]),
        .in_tag     (meta_q[PIPE_LAT-1].tag),
        .in_val     (pred),
        .out_valid  (out_valid),
        .out_app    (out_app),
        .out_tag    (out_tag),
        .out_mean   (out_mean),
        .out_spread (out_spread)
    );
endmodule

// File: rtl/np_predictor_chk.sv
module np_predictor_chk #(
    parameter int LAT = 17
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        wr_en,
    input logic        out_valid,
    input logic [15:0] out_mean,
    input logic [15:0] out_spread
);
    logic [LAT-1:0] vq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vq <= '0;
        end else begin
            vq <= {vq[LAT-2:0], in_valid};
        end
    end

    // R1: reset leaves no result pending
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R5: a result needs an accepted input exactly LAT edges before
    p_valid_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> vq[LAT-1]);

    // R3: the mean stays inside the activation table's range
    p_mean_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mean >= 16'd18 && out_mean <= 16'd237));

    // R9: the spread cannot exceed four times the table's span
    p_spread_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_spread <= 16'd876);

    // R7: weights are only written while no evaluation is entering
    p_write_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !in_valid);
endmodule

bind np_predictor np_predictor_chk #(.LAT(np_pkg::TOTAL_LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .wr_en      (wr_en),
    .out_valid  (out_valid),
    .out_mean   (out_mean),
    .out_spread (out_spread)
);

// File: tb/tb_np_predictor.sv
module tb_np_predictor;
    localparam int NSLOT = 8192;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_sel = '0;
    logic [7:0]   in_tag = '0;
    logic [191:0] in_x = '0;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_set = '0;
    logic [5:0]   wr_idx = '0;
    logic [15:0]  wr_data = '0;
    logic         out_valid;
    logic [1:0]   out_app;
    logic [7:0]   out_tag;
    logic [15:0]  out_mean;
    logic [15:0]  out_spread;

    np_predictor dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sel(in_sel),
        .in_tag(in_tag), .in_x(in_x), .wr_en(wr_en), .wr_set(wr_set),
        .wr_idx(wr_idx), .wr_data(wr_data), .out_valid(out_valid),
        .out_app(out_app), .out_tag(out_tag), .out_mean(out_mean),
        .out_spread(out_spread)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int edges = 0;
    int out_cnt = 0;
    int last_mean = 0, last_spr = 0, last_app = 0, last_tag = 0, last_edge = 0;
    bit done = 0;
    string scen = "R1";

    int  wm [16][57];
    int  xin [12];
    int  mv [4][4];
    bit [3:0] mhave [4];
    bit  ev  [NSLOT];
    int  eapp[NSLOT], etag[NSLOT], emean[NSLOT], espr[NSLOT];

    always @(posedge clk) edges <= edges + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int act_of(input longint s);
        longint d;
        d = s >>> 14;
        if (d < -25) d = -25;
        if (d > 24) d = 24;
        return 128 + int'((128 * d) / (((d < 0) ? -d : d) + 4));
    endfunction

    function automatic int net_eval(input int sel);
        int a [4];
        longint s;
        for (int h = 0; h < 4; h++) begin
            s = longint'(wm[sel][h*13]) * 256;
            for (int i = 0; i < 12; i++) s += longint'(xin[i]) * longint'(wm[sel][h*13+1+i]);
            a[h] = act_of(s);
        end
        s = longint'(wm[sel][52]) * 256;
        for (int h = 0; h < 4; h++) s += longint'(a[h]) * longint'(wm[sel][53+h]);
        return act_of(s);
    endfunction

    // per-cycle comparison against the model's scheduled slots
    always @(negedge clk) begin
        if (rst_n && edges < NSLOT) begin
            if (ev[edges] || out_valid) begin
                bit ok;
                ok = 1;
                n_checks++;
                if (out_valid !== ev[edges]) begin
                    ok = 0;
                    $display("FAIL %s R5 out_valid: got %0d expected %0d (edge %0d)", scen, out_valid, ev[edges], edges);
                end else begin
                    if (int'(out_app) != eapp[edges] || int'(out_tag) != etag[edges]) begin
                        ok = 0;
                        $display("FAIL %s R10 app/tag: got %0d/%0d expected %0d/%0d", scen, out_app, out_tag, eapp[edges], etag[edges]);
                    end
                    if (int'(out_mean) != emean[edges]) begin
                        ok = 0;
                        $display("FAIL %s R8 mean: got %0d expected %0d", scen, out_mean, emean[edges]);
                    end
                    if (int'(out_spread) != espr[edges]) begin
                        ok = 0;
                        $display("FAIL %s R9 spread: got %0d expected %0d", scen, out_spread, espr[edges]);
                    end
                end
                if (!ok) n_fail++;
            end
            if (out_valid) begin
                out_cnt++;
                last_mean = int'(out_mean);
                last_spr  = int'(out_spread);
                last_app  = int'(out_app);
                last_tag  = int'(out_tag);
                last_edge = edges;
            end
        end
    end

    int last_send_edge = 0;

    task automatic send(input int sel, input int tag);
        int app, memb, slot, sum, mean, spr;
        @(negedge clk);
        wr_en    = 1'b0;
        in_valid = 1'b1;
        in_sel   = 4'(sel);
        in_tag   = 8'(tag);
        for (int i = 0; i < 12; i++) in_x[i*16 +: 16] = 16'(xin[i]);
        last_send_edge = edges + 1;
        app  = sel / 4;
        memb = sel % 4;
        mv[app][memb] = net_eval(sel);
        mhave[app][memb] = 1'b1;
        if (mhave[app] == 4'hF) begin
            mhave[app] = '0;
            sum = 0;
            for (int m = 0; m < 4; m++) sum += mv[app][m];
            mean = sum / 4;
            spr = 0;
            for (int m = 0; m < 4; m++) spr += (mv[app][m] >= mean) ? mv[app][m] - mean : mean - mv[app][m];
            slot = edges + 17;
            if (slot < NSLOT) begin
                ev[slot] = 1;
                eapp[slot] = app;
                etag[slot] = tag;
                emean[slot] = mean;
                espr[slot] = spr;
            end
        end
    endtask

    task automatic wr(input int set, input int idx, input int val);
        @(negedge clk);
        in_valid = 1'b0;
        wr_en    = 1'b1;
        wr_set   = 4'(set);
        wr_idx   = 6'(idx);
        wr_data  = 16'(val);
        wm[set][idx] = val;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        wr_en    = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic rand_x(input int mag);
        for (int i = 0; i < 12; i++) xin[i] = int'($urandom_range(2 * mag)) - mag;
    endtask

    task automatic query_point(input int tag);
        for (int s = 0; s < 16; s++) send(s, tag);
    endtask

    initial begin
        int c0;
        for (int s = 0; s < 16; s++) for (int k = 0; k < 57; k++) wm[s][k] = 0;
        for (int a = 0; a < 4; a++) mhave[a] = '0;
        for (int k = 0; k < NSLOT; k++) ev[k] = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

        // unwritten weights: every unit sits at the table centre
        scen = "R1/R3";
        rand_x(256);
        c0 = out_cnt;
        query_point(1);
        idle(20);
        check(out_cnt - c0 == 4, "R6 results per query point", out_cnt - c0, 4);
        check(last_mean == 128, "R3 zero-sum activation", last_mean, 128);
        check(last_spr == 0, "R1 spread with cleared weights", last_spr, 0);

        // distinct random weights in every set
        scen = "R2/R7/R11";
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 52; k++) wr(s, k, int'($urandom_range(128)) - 64);
            for (int k = 52; k < 57; k++) wr(s, k, int'($urandom_range(512)) - 256);
        end
        idle(2);
        c0 = out_cnt;
        for (int q = 0; q < 3; q++) begin
            rand_x(256);
            query_point(16 + q);
        end
        idle(20);
        check(out_cnt - c0 == 12, "R6 back-to-back query points", out_cnt - c0, 12);

        // isolated application: latency R5
        scen = "R5";
        rand_x(200);
        for (int s = 12; s < 16; s++) send(s, 40);
        idle(25);
        check(last_edge - last_send_edge == 16, "R5 latency in edges", last_edge - last_send_edge, 16);

        // saturation: application 1 high clamp, application 2 low clamp
        scen = "R4";
        for (int s = 4; s < 12; s++) begin
            for (int k = 0; k < 52; k++) wr(s, k, 30000);
            for (int k = 52; k < 57; k++) wr(s, k, (s < 8) ? 30000 : -30000);
        end
        for (int i = 0; i < 12; i++) xin[i] = 30000;
        for (int s = 4; s < 8; s++) send(s, 50);
        idle(20);
        check(last_mean == 237, "R4 upper clamp", last_mean, 237);
        for (int s = 8; s < 12; s++) send(s, 51);
        idle(20);
        check(last_mean == 18, "R4 lower clamp", last_mean, 18);

        // members out of order, partial application must wait
        scen = "R10";
        rand_x(256);
        c0 = out_cnt;
        send(11, 60); send(9, 61); send(8, 62);
        idle(25);
        check(out_cnt == c0, "R10 no release with three members", out_cnt - c0, 0);
        send(10, 90);
        idle(20);
        check(last_tag == 90 && last_app == 2, "R10 tag/app of last member", last_tag * 4 + last_app, 90 * 4 + 2);

        // interleaved applications with changing selection each cycle
        scen = "R10/R11";
        rand_x(300);
        c0 = out_cnt;
        send(0, 70); send(12, 71); send(1, 72); send(13, 73);
        send(2, 74); send(14, 75); send(3, 76); send(15, 77);
        idle(20);
        check(out_cnt - c0 == 2, "R10 interleaved releases", out_cnt - c0, 2);

        // weight rewrite affects later evaluations
        scen = "R7";
        wr(0, 52, 2000);
        wr(1, 3, -100);
        idle(2);
        rand_x(256);
        query_point(99);
        idle(20);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule